// File: doc/BRIEF.md
# Branch Condition Evaluator

This unit decides whether a conditional jump in a small sequencer is taken. Each cycle it takes two 16-bit operands, a 5-bit condition code and the side inputs that some conditions need. The side inputs are a shift amount and a mask length for bit-field tests, and a 6-bit index into a 64-bit vector of external event bits. It returns one registered taken flag. The sequencer applies the operands and the code in one cycle and reads the decision on the next clock edge. Target address calculation and the program counter stay outside this block.

The conditions fall into several groups: bitwise tests, equality, signed and unsigned ordering, and tests on the sign of the wrapped difference a-b. There is also a zero test on a shifted and masked field of operand a, and a selectable external event bit. Every condition has an inverse form. One code is always true, so an unconditional jump uses the same path as the others.

Top module: `branch_cond_eval`

## Requirements
- R1: While `rst` is high at a rising clock edge, `taken_o` becomes 0 at that edge, whatever the other inputs are.
- R2: `taken_o` shows the decision for the inputs sampled at the previous rising edge. Code 0 is always taken.
- R3: Code 1 is taken when `opa_i & opb_i` is nonzero. Code 2 is taken when it is zero.
- R4: Code 3 is taken when every bit set in `opb_i` is also set in `opa_i`. Code 4 is taken otherwise.
- R5: Code 5 is taken when the operands are equal. Code 6 is taken when they differ.
- R6: Signed ordering, with both operands read as two's complement. Code 7 is a<b, code 8 is a>=b, code 9 is a>b and code 10 is a<=b.
- R7: Unsigned ordering. Code 11 is a<b, code 12 is a>=b, code 13 is a>b and code 14 is a<=b.
- R8: Let d = (a-b) mod 2^16, read as a signed value. Code 15 is taken when d<0, code 16 when d>=0, code 17 when d>0 and code 18 when d<=0.
- R9: Let f = (opa_i >> `shamt_i`) AND a mask of `mlen_i`+1 low-order ones. Code 19 is taken when f is zero and code 20 when f is nonzero. `mlen_i`=15 keeps all 16 bits.
- R10: Code 21 is taken when `ext_vec_i[ext_idx_i]` is 1, and code 22 when that bit is 0. Every index from 0 to 63 is valid, including 0x24.
- R11: Codes 23 to 31 are never taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_i | input | 5 | Condition code |
| opa_i | input | 16 | Operand a |
| opb_i | input | 16 | Operand b |
| shamt_i | input | 4 | Right-shift amount for the field test |
| mlen_i | input | 4 | Field width minus one for the field test |
| ext_idx_i | input | 6 | External condition selector |
| ext_vec_i | input | 64 | External condition bits |
| taken_o | output | 1 | Registered jump decision |

## Verification
The only state in the block is the decision register. A wrong value in it, or a wrong flag from any comparison path, appears at `taken_o` exactly one cycle after the inputs that caused it, and it does not carry over into later cycles. Every condition therefore gets a per-cycle comparison against a behavioural model. The stimulus targets the cases that separate the flag paths from one another. Examples are operands with 0x8000 against 1, where the signed and unsigned orderings disagree and the difference wraps, a full-width field mask, the largest shift amount, and the edge and middle external indices.

// File: rtl/bce_pkg.sv
package bce_pkg;

    typedef enum logic [4:0] {
        CC_ALWAYS   = 5'd0,
        CC_ANY_SET  = 5'd1,
        CC_NONE_SET = 5'd2,
        CC_ALL_IN   = 5'd3,
        CC_NOT_ALL  = 5'd4,
        CC_EQ       = 5'd5,
        CC_NE       = 5'd6,
        CC_SLT      = 5'd7,
        CC_SGE      = 5'd8,
        CC_SGT      = 5'd9,
        CC_SLE      = 5'd10,
        CC_ULT      = 5'd11,
        CC_UGE      = 5'd12,
        CC_UGT      = 5'd13,
        CC_ULE      = 5'd14,
        CC_DNEG     = 5'd15,
        CC_DNNEG    = 5'd16,
        CC_DPOS     = 5'd17,
        CC_DNPOS    = 5'd18,
        CC_FZERO    = 5'd19,
        CC_FNZERO   = 5'd20,
        CC_EXT_HI   = 5'd21,
        CC_EXT_LO   = 5'd22
    } cond_e;

    localparam logic [4:0] CC_LAST_VALID = 5'd22;

    // Primitive flags produced by the operand comparator.
    typedef struct packed {
        logic any_set;   // a & b != 0
        logic all_in;    // (a & b) == b
        logic eq;        // a == b
        logic slt;       // signed a < b
        logic ult;       // unsigned a < b
        logic dneg;      // wrapped difference sign bit
        logic dzero;     // wrapped difference is zero
    } cmp_flags_t;

    // Low-order mask of (len+1) ones, saturating at the full width.
    function automatic logic [31:0] low_ones(input int unsigned len, input int unsigned width);
        logic [32:0] m;
        int unsigned n;
        n = len + 1;
        if (n > width) n = width;
        m = (33'd1 << n) - 33'd1;
        return m[31:0];
    endfunction

endpackage

// File: rtl/bce_compare.sv
module bce_compare
    import bce_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output cmp_flags_t        flags
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] conj;
    logic [DATA_W:0]   diff_ext;
    logic [DATA_W-1:0] diff;
    logic              sign_a;
    logic              sign_b;

    always_comb begin
        conj     = opa & opb;
        // Extended subtraction: the borrow bit is the unsigned less-than.
        diff_ext = {1'b0, opa} - {1'b0, opb};
        diff     = diff_ext[DATA_W-1:0];
        sign_a   = opa[MSB];
        sign_b   = opb[MSB];

        flags.any_set = |conj;
        flags.all_in  = (conj == opb);
        flags.eq      = (opa == opb);
        flags.ult     = diff_ext[DATA_W];
        // Signed order: differing signs decide directly, else unsigned order.
        flags.slt     = (sign_a != sign_b) ? sign_a : diff_ext[DATA_W];
        flags.dneg    = diff[MSB];
        flags.dzero   = ~|diff;
    end

endmodule

// File: rtl/bce_field.sv
module bce_field
    import bce_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int SH_W   = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [SH_W-1:0]   shamt,
    input  logic [SH_W-1:0]   mlen,
    output logic              field_zero
);
    logic [DATA_W-1:0] shifted;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] masked;

    // Mask built bit by bit: bit k is kept when k <= mlen.
    for (genvar k = 0; k < DATA_W; k++) begin : g_mask
        assign mask[k] = (k <= int'(mlen));
    end

    always_comb begin
        shifted    = opa >> shamt;
        masked     = shifted & mask;
        field_zero = ~|masked;
    end

    // Full-width, unshifted field must reduce to a plain zero test. R9
    always_comb begin
        if (shamt == '0 && mlen == SH_W'(DATA_W - 1))
            AST_FIELD_FULL: assert (field_zero == (opa == '0)); // R9
    end

endmodule

// File: rtl/bce_extsel.sv
module bce_extsel #(
    parameter int EXT_N = 64,
    parameter int IDX_W = $clog2(EXT_N)
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [EXT_N-1:0] vec,
    output logic             bit_o
);
    logic [EXT_N-1:0] hit;

    // One-hot decode of the selector, then AND-OR reduction.
    for (genvar i = 0; i < EXT_N; i++) begin : g_hit
        assign hit[i] = (idx == IDX_W'(i)) & vec[i];
    end

    assign bit_o = |hit;

endmodule

// File: rtl/branch_cond_eval.sv
module branch_cond_eval
    import bce_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int EXT_N  = 64,
    localparam int SH_W  = $clog2(DATA_W),
    localparam int IDX_W = $clog2(EXT_N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [4:0]        cond_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic [SH_W-1:0]   shamt_i,
    input  logic [SH_W-1:0]   mlen_i,
    input  logic [IDX_W-1:0]  ext_idx_i,
    input  logic [EXT_N-1:0]  ext_vec_i,
    output logic              taken_o
);
    cmp_flags_t flags;
    logic       field_zero;
    logic       ext_bit;
    logic       base;
    logic       invert;
    logic       decide;

    bce_compare #(.DATA_W(DATA_W)) u_cmp (
        .opa   (opa_i),
        .opb   (opb_i),
        .flags (flags)
    );

    bce_field #(.DATA_W(DATA_W), .SH_W(SH_W)) u_field (
        .opa        (opa_i),
        .shamt      (shamt_i),
        .mlen       (mlen_i),
        .field_zero (field_zero)
    );

    bce_extsel #(.EXT_N(EXT_N), .IDX_W(IDX_W)) u_ext (
        .idx   (ext_idx_i),
        .vec   (ext_vec_i),
        .bit_o (ext_bit)
    );

    // Each code selects a base predicate and whether to invert it.
    always_comb begin
        base   = 1'b0;
        invert = 1'b0;
        case (cond_i)
            CC_ALWAYS:   begin base = 1'b1;                     invert = 1'b0; end
            CC_ANY_SET:  begin base = flags.any_set;            invert = 1'b0; end
            CC_NONE_SET: begin base = flags.any_set;            invert = 1'b1; end
            CC_ALL_IN:   begin base = flags.all_in;             invert = 1'b0; end
            CC_NOT_ALL:  begin base = flags.all_in;             invert = 1'b1; end
            CC_EQ:       begin base = flags.eq;                 invert = 1'b0; end
            CC_NE:       begin base = flags.eq;                 invert = 1'b1; end
            CC_SLT:      begin base = flags.slt;                invert = 1'b0; end
            CC_SGE:      begin base = flags.slt;                invert = 1'b1; end
            CC_SGT:      begin base = flags.slt | flags.eq;     invert = 1'b1; end
            CC_SLE:      begin base = flags.slt | flags.eq;     invert = 1'b0; end
            CC_ULT:      begin base = flags.ult;                invert = 1'b0; end
            CC_UGE:      begin base = flags.ult;                invert = 1'b1; end
            CC_UGT:      begin base = flags.ult | flags.eq;     invert = 1'b1; end
            CC_ULE:      begin base = flags.ult | flags.eq;     invert = 1'b0; end
            CC_DNEG:     begin base = flags.dneg;               invert = 1'b0; end
            CC_DNNEG:    begin base = flags.dneg;               invert = 1'b1; end
            CC_DPOS:     begin base = flags.dneg | flags.dzero; invert = 1'b1; end
            CC_DNPOS:    begin base = flags.dneg | flags.dzero; invert = 1'b0; end
            CC_FZERO:    begin base = field_zero;               invert = 1'b0; end
            CC_FNZERO:   begin base = field_zero;               invert = 1'b1; end
            CC_EXT_HI:   begin base = ext_bit;                  invert = 1'b0; end
            CC_EXT_LO:   begin base = ext_bit;                  invert = 1'b1; end
            default:     begin base = 1'b0;                     invert = 1'b0; end
        endcase
        decide = base ^ invert;
    end

    always_ff @(posedge clk) begin
        if (rst) taken_o <= 1'b0;
        else     taken_o <= decide;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> !taken_o); // R1

    AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (cond_i == CC_ALWAYS) |=> taken_o); // R2

    AST_EQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (cond_i == CC_EQ) |=> (taken_o == $past(opa_i == opb_i))); // R5

    AST_ULT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (cond_i == CC_ULT) |=> (taken_o == $past(opa_i < opb_i))); // R7

    AST_EXT_HI: assert property (@(posedge clk) disable iff (rst)
        (cond_i == CC_EXT_HI) |=> (taken_o == $past(ext_bit))); // R10

    AST_RSVD_NEVER: assert property (@(posedge clk) disable iff (rst)
        (cond_i > CC_LAST_VALID) |=> !taken_o); // R11

endmodule

// File: tb/tb_branch_cond_eval.sv
`timescale 1ns/1ps
module tb_branch_cond_eval;

    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  cond_i;
    logic [15:0] opa_i, opb_i;
    logic [3:0]  shamt_i, mlen_i;
    logic [5:0]  ext_idx_i;
    logic [63:0] ext_vec_i;
    logic        taken_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    branch_cond_eval dut (
        .clk(clk), .rst(rst), .cond_i(cond_i), .opa_i(opa_i), .opb_i(opb_i),
        .shamt_i(shamt_i), .mlen_i(mlen_i), .ext_idx_i(ext_idx_i),
        .ext_vec_i(ext_vec_i), .taken_o(taken_o)
    );

    function automatic string req_of(input int c);
        if (c == 0) return "R2";
        if (c <= 2) return "R3";
        if (c <= 4) return "R4";
        if (c <= 6) return "R5";
        if (c <= 10) return "R6";
        if (c <= 14) return "R7";
        if (c <= 18) return "R8";
        if (c <= 20) return "R9";
        if (c <= 22) return "R10";
        return "R11";
    endfunction

    // Behavioural model written from the requirements.
    function automatic bit model(input int c, input int a, input int b,
                                 input int s, input int m, input int ix,
                                 input logic [63:0] v);
        int sa, sb, d, f;
        sa = (a >= 32768) ? a - 65536 : a;
        sb = (b >= 32768) ? b - 65536 : b;
        d  = (a - b) & 65535;
        if (d >= 32768) d = d - 65536;
        f  = (a / (1 << s)) % (1 << (m + 1));
        case (c)
            0:  return 1;
            1:  return (a & b) != 0;
            2:  return (a & b) == 0;
            3:  return (a & b) == b;
            4:  return (a & b) != b;
            5:  return a == b;
            6:  return a != b;
            7:  return sa < sb;
            8:  return sa >= sb;
            9:  return sa > sb;
            10: return sa <= sb;
            11: return a < b;
            12: return a >= b;
            13: return a > b;
            14: return a <= b;
            15: return d < 0;
            16: return d >= 0;
            17: return d > 0;
            18: return d <= 0;
            19: return f == 0;
            20: return f != 0;
            21: return v[ix] == 1'b1;
            22: return v[ix] == 1'b0;
            default: return 0;
        endcase
    endfunction

    task automatic check(input bit exp, input string tag);
        checks++;
        if (taken_o !== exp) begin
            errors++;
            $display("FAIL %s cond=%0d actual=%b expected=%b", tag, cond_i, taken_o, exp);
        end
    endtask

    // Called at a falling edge: apply inputs, wait one cycle, compare.
    task automatic step(input int c, input int a, input int b, input int s,
                        input int m, input int ix, input logic [63:0] v);
        bit exp;
        cond_i = 5'(c); opa_i = 16'(a); opb_i = 16'(b);
        shamt_i = 4'(s); mlen_i = 4'(m); ext_idx_i = 6'(ix); ext_vec_i = v;
        exp = model(c, a, b, s, m, ix, v);
        @(negedge clk);
        check(exp, req_of(c));
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] v;
        rst = 1'b1; cond_i = 5'd0; opa_i = '0; opb_i = '0;
        shamt_i = '0; mlen_i = '0; ext_idx_i = '0; ext_vec_i = '0;
        repeat (3) @(negedge clk);
        check(1'b0, "R1");            // reset state, code 0 applied
        rst = 1'b0;
        step(0, 0, 0, 0, 0, 0, '0);   // R2 always taken after release
        rst = 1'b1;
        @(negedge clk);
        check(1'b0, "R1");            // reset dominates an always-true code
        rst = 1'b0;

        // R3, R4 bitwise
        step(1, 16'h00F0, 16'h0F00, 0, 0, 0, '0);
        step(2, 16'h00F0, 16'h0F00, 0, 0, 0, '0);
        step(3, 16'hFF0F, 16'h0F0F, 0, 0, 0, '0);
        step(4, 16'hFF0F, 16'h0F1F, 0, 0, 0, '0);
        step(3, 16'h1234, 16'h0000, 0, 0, 0, '0);
        // R5
        step(5, 16'hBEEF, 16'hBEEF, 0, 0, 0, '0);
        step(6, 16'hBEEF, 16'hBEEF, 0, 0, 0, '0);
        // R6, R7, R8 at the sign boundary: 0x8000 vs 1
        for (int c = 7; c <= 18; c++) step(c, 16'h8000, 16'h0001, 0, 0, 0, '0);
        for (int c = 7; c <= 18; c++) step(c, 16'h7FFF, 16'h7FFF, 0, 0, 0, '0);
        for (int c = 7; c <= 18; c++) step(c, 16'hFFFF, 16'h0000, 0, 0, 0, '0);
        // R9 field: full mask, maximum shift, narrow field
        step(19, 16'h0000, 0, 0, 15, 0, '0);
        step(20, 16'h8000, 0, 15, 0, 0, '0);
        step(19, 16'h0180, 0, 7, 0, 0, '0);
        step(19, 16'h0180, 0, 8, 1, 0, '0);
        step(20, 16'h0040, 0, 7, 3, 0, '0);
        // R10 external bits: indices 0, 0x24, 63
        v = 64'h8000_0010_0000_0001;
        step(21, 0, 0, 0, 0, 6'h24, v);
        step(22, 0, 0, 0, 0, 6'h24, v);
        step(21, 0, 0, 0, 0, 63, v);
        step(21, 0, 0, 0, 0, 0, v);
        step(21, 0, 0, 0, 0, 1, v);
        step(22, 0, 0, 0, 0, 2, v);
        // R11 reserved codes, with inputs that make other codes true
        for (int c = 23; c <= 31; c++) step(c, 16'h5555, 16'h5555, 0, 15, 0, '1);

        // Mixed patterns over every code
        for (int n = 0; n < 4000; n++) begin
            int a, b;
            a = int'($urandom_range(0, 65535));
            case ($urandom_range(0, 3))
                0: b = a;
                1: b = a & int'($urandom_range(0, 65535));
                default: b = int'($urandom_range(0, 65535));
            endcase
            step(int'($urandom_range(0, 31)), a, b, int'($urandom_range(0, 15)),
                 int'($urandom_range(0, 15)), int'($urandom_range(0, 63)),
                 {$urandom, $urandom});
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule